// File: doc/BRIEF.md
# Counter-Addressed Lookup Table Memory

This block is a 1024-word by 24-bit table that maps a 10-bit pixel value onto a 24-bit output word. It has two modes, chosen by the `start` input. While `start` is low the block fills its table: an internal address counter begins at entry 0 and moves up by one on every clock. The word on `din` is written at the counter address. In the same slot the word that was stored there before the write appears on `dout`. Once the last entry has been written, the counter stays where it is and the table is protected from further writes until the next fill.

While `start` is high the block is a lookup table. The value on `pix_in` is registered as an address, and the stored word comes out three clock cycles after the pixel was presented. The active-low `rd_n` input travels through the pipeline with each address. A slot whose `rd_n` was high produces zero on `dout`, which stands in for an undriven bus. The storage is an inferred synchronous RAM with no reset, so its contents are undefined until it has been filled.

Top module: `lut_counter_mem`

## Requirements
- R1: The table holds 1024 words of 24 bits, addressed by a 10-bit value; entries 0 and 1023 are both reachable in each mode.
- R2: While `start` is high the fill counter is held at 0, so the first cycle with `start` low addresses entry 0, whatever an earlier fill reached.
- R3: In each fill cycle the counter address goes up by one, and the `din` word of that cycle is stored at that cycle's counter address.
- R4: After entry 1023 has been written, the counter stays at 1023 and every later fill cycle writes nothing, until `start` goes high again.
- R5: In a fill cycle with `rd_n` low, the output slot for that cycle carries the contents of the counter address from before that cycle's write.
- R6: With `start` high, `pix_in` is the address. The stored word appears on `dout` three rising edges after the cycle in which the pixel was presented, and no writes happen.
- R7: An input cycle with `rd_n` high yields a `dout` of zero in its output slot, three edges later.
- R8: A pixel presented from the third cycle after `start` rises reads table contents that include every write of the preceding fill.
- R9: During and right after synchronous reset (`rst_n` low), `dout` is zero and the fill counter is at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Low: fill mode; high: lookup mode |
| pix_in | input | 10 | Pixel value used as lookup address |
| din | input | 24 | Word to store during fill mode |
| rd_n | input | 1 | Active-low output enable, pipelined with the address |
| dout | output | 24 | Looked-up or previous word, zero when disabled |

## Verification
The hardest condition to reach from the ports is the saturated counter, where later fill cycles are silently dropped. Reaching it takes more than 1024 consecutive fill cycles. The stimulus therefore runs a second fill that is longer than the table, with overflow words that differ from everything stored before. A lookup of entry 1023 afterwards must return the word written at the boundary and none of the overflow words. A short fill that is cut off early and then restarted shows the counter clearing. In that case the output slots of the restarted fill show the words written by the short fill.

// File: rtl/lut_mem_pkg.sv
// Package: shared sizes for the counter-addressed lookup memory.
// Assumes: power-of-two table depth; address width derived from depth.
package lut_mem_pkg;
    parameter int unsigned LUT_DEPTH  = 1024;
    parameter int unsigned WORD_W     = 24;
    localparam int unsigned ADDR_W    = $clog2(LUT_DEPTH);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(LUT_DEPTH - 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    // One pipeline slot entering the memory stage.
    typedef struct packed {
        addr_t addr;
        logic  wr_en;
        logic  rd_off;
    } slot_t;
endpackage

// File: rtl/lut_delay_line.sv
// Module: lut_delay_line
// Delays a bus by STAGES clock cycles using a chain of registers.
// Assumes: STAGES >= 1; registers clear to zero in synchronous reset.
module lut_delay_line #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] taps [STAGES+1];

    assign taps[0] = d_in;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift one register stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) taps[g+1] <= '0;
            else        taps[g+1] <= taps[g];
        end
    end

    assign d_out = taps[STAGES];
endmodule

// File: rtl/lut_addr_ctrl.sv
// Module: lut_addr_ctrl
// Owns the fill counter and the first pipeline stage. In fill mode the
// counter supplies the address and a write is requested until the last
// entry has been written; in lookup mode the pixel is the address.
// Assumes: start is synchronous to clk.
module lut_addr_ctrl
    import lut_mem_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  addr_t pix_in,
    input  logic  rd_n,
    output slot_t slot_s1,
    output addr_t fill_cnt
);
    addr_t cnt_q;
    logic  full_q;   // last entry already written in this fill

    // Fill counter: clear in lookup mode, climb and stop at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= '0;
        else if (cnt_q != LAST_ADDR) cnt_q <= cnt_q + 1'b1;
    end

    // Table-full flag: set once the last entry is written, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  full_q <= 1'b0;
        else if (start)              full_q <= 1'b0;
        else if (cnt_q == LAST_ADDR) full_q <= 1'b1;
    end

    // Stage-1 register: choose the address source and the write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_s1 <= '0;
        end else begin
            slot_s1.addr   <= start ? pix_in : cnt_q;
            slot_s1.wr_en  <= !start && !full_q;
            slot_s1.rd_off <= rd_n;
        end
    end

    assign fill_cnt = cnt_q;

    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != LAST_ADDR) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q == LAST_ADDR) |=> (cnt_q == LAST_ADDR));
    p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && full_q) |=> !slot_s1.wr_en);
    p_no_write_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !slot_s1.wr_en);
endmodule

// File: rtl/lut_ram.sv
// Module: lut_ram
// Single-port synchronous RAM; a read and a write may share an edge,
// and a read of the entry being written returns the old word.
// Assumes: no reset of contents; read data is registered.
module lut_ram
    import lut_mem_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  addr_t addr,
    input  word_t wr_data,
    output word_t rd_data
);
    word_t mem [LUT_DEPTH];

    // Read the old word and store the new one on the same edge.
    always_ff @(posedge clk) begin
        rd_data <= mem[addr];
        if (wr_en) mem[addr] <= wr_data;
    end
endmodule

// File: rtl/lut_counter_mem.sv
// Module: lut_counter_mem (top)
// Counter-filled lookup table: three-edge latency from the input cycle to
// dout. Edge 1 selects the address, edge 2 reads and writes the RAM,
// edge 3 registers the output (zero when the slot's rd_n was high).
// Assumes: pixels for lookup arrive from the third cycle after start rises.
module lut_counter_mem
    import lut_mem_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         pix_in,
    input  logic [WORD_W-1:0]         din,
    input  logic                      rd_n,
    output logic [WORD_W-1:0]         dout
);
    slot_t slot_s1;
    addr_t fill_cnt;
    word_t din_s1;
    word_t ram_q;
    logic  rd_off_s2;
    word_t dout_q;

    lut_addr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pix_in   (pix_in),
        .rd_n     (rd_n),
        .slot_s1  (slot_s1),
        .fill_cnt (fill_cnt)
    );

    lut_delay_line #(.WIDTH(WORD_W), .STAGES(1)) u_din_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (din),
        .d_out (din_s1)
    );

    lut_ram u_ram (
        .clk     (clk),
        .wr_en   (slot_s1.wr_en),
        .addr    (slot_s1.addr),
        .wr_data (din_s1),
        .rd_data (ram_q)
    );

    lut_delay_line #(.WIDTH(1), .STAGES(1)) u_rd_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (slot_s1.rd_off),
        .d_out (rd_off_s2)
    );

    // Output register: pass the RAM word or force zero for a disabled slot.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= rd_off_s2 ? '0 : ram_q;
    end

    assign dout = dout_q;

    p_dout_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_off_s2 |=> (dout == '0));
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && fill_cnt == '0));
endmodule

// File: tb/test_lut_counter_mem.sv
module test_lut_counter_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b1;
    logic [9:0]  pix_in = '0;
    logic [23:0] din = '0;
    logic        rd_n = 1'b1;
    logic [23:0] dout;

    lut_counter_mem i_lut_counter_mem (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_in(pix_in),
        .din(din), .rd_n(rd_n), .dout(dout)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // Behavioural reference state.
    int unsigned ref_mem [1024];
    bit          known   [1024];
    int          cnt_m   = 0;
    bit          full_m  = 0;
    bit          prev_st = 1;
    int          gap     = 0;
    bit          first_fill = 0;
    logic [31:0] lfsr = 32'h1BADF00D;

    logic [23:0] q_val [$];
    bit          q_vld [$];
    string       q_tag [$];

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One input cycle: compare the slot from three cycles ago, then drive.
    task automatic step(input bit st, input logic [9:0] px, input logic [23:0] d, input bit rdn);
        int a;
        bit v;
        logic [23:0] e;
        string t;
        @(negedge clk);
        if (q_val.size() == 3) begin
            e = q_val.pop_front();
            v = q_vld.pop_front();
            t = q_tag.pop_front();
            if (v) check(t, dout, e);
        end
        if (st && !prev_st) gap = 2;
        a = st ? int'(px) : cnt_m;
        v = rdn || (known[a] && !(st && gap > 0));
        e = rdn ? 24'h0 : 24'(ref_mem[a]);
        if (rdn)                  t = "R7";
        else if (st && gap == 0 && prev_st && first_fill) t = "R8";
        else if (st)              t = (a == 0 || a == 1023) ? "R1 R6" : "R3 R6";
        else if (full_m)          t = "R4";
        else if (prev_st)         t = "R2";
        else                      t = "R5";
        if (st && gap == 0) first_fill = 0;
        if (!st && !full_m) begin
            ref_mem[a] = int'(d);
            known[a] = 1;
        end
        if (st) begin
            cnt_m = 0; full_m = 0;
            if (gap > 0) gap--;
        end else if (cnt_m == 1023) full_m = 1;
        else cnt_m++;
        if (!st) first_fill = 1;
        prev_st = st;
        q_val.push_back(e); q_vld.push_back(v); q_tag.push_back(t);
        start = st; pix_in = px; din = d; rd_n = rdn;
    endtask

    task automatic fill(input int n, input logic [23:0] base);
        for (int i = 0; i < n; i++) begin
            lfsr = nxt(lfsr);
            step(0, '0, base ^ 24'(i * 37) ^ 24'(lfsr[7:0]), lfsr[9] & lfsr[3]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, '0, '0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", dout, 24'h0);
        // Short fill cut off early, then full fill restarting from entry 0.
        fill(5, 24'hA00000);
        idle(3);
        fill(1030, 24'h5A0000);
        idle(3);
        // Lookup: boundaries, sweep, pseudo-random, read-enable toggling.
        step(1, 10'd0, '0, 0);
        step(1, 10'd1023, '0, 0);
        for (int i = 0; i < 1024; i += 7) step(1, 10'(i), '0, 0);
        for (int i = 0; i < 400; i++) begin
            lfsr = nxt(lfsr);
            step(1, lfsr[9:0], '0, lfsr[20] & lfsr[11]);
        end
        // Second fill, much longer than the table, overflow words distinct.
        fill(1024, 24'h330000);
        for (int i = 0; i < 300; i++) step(0, '0, 24'hEE0000 | 24'(i), 0);
        idle(3);
        step(1, 10'd1023, '0, 0);
        step(1, 10'd1022, '0, 0);
        step(1, 10'd0, '0, 0);
        for (int i = 0; i < 200; i++) begin
            lfsr = nxt(lfsr);
            step(1, lfsr[9:0], '0, lfsr[5] & lfsr[17] & lfsr[2]);
        end
        idle(4);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule